// File: doc/BRIEF.md
# Pulse Output Error Monitor

This block watches a pulse-width-modulated signal coming out of a design under test and compares it, cycle by cycle, with a fault-free copy of the same waveform. Both signals are sampled on one clock. A start strobe opens an evaluation window and an end strobe closes it. While the window is open the block counts the cycles in which the two signals differ and the cycles in which each one is high.

Two verdicts come out side by side. The strict flag reports any disagreement at all. The tolerant flag reports only deviations that matter: a rising edge that lands too far from the reference edge, or a total high time that differs from the reference by more than a programmed amount. A pulse that is shifted a little, or that drops out briefly and recovers, passes the tolerant check. The block is meant for fault-injection campaigns, where each run is classified both by the strict and by the tolerant criterion.

Top module: `pulse_err_monitor`

## Requirements
- R1: After a synchronous reset all counts are zero and `strictErr`, `tolErr`, `windowOpen` and `done` are low.
- R2: A `winStart` cycle is not sampled. From the next cycle all counts and both flags are zero and `windowOpen` is high. This holds also when a window is already open, which restarts it. `winStart` wins over a `winEnd` in the same cycle.
- R3: In every sampled cycle where `dutPulse` differs from `refPulse`, `mismatchCount` rises by one.
- R4: `dutHighCount` and `refHighCount` each count the sampled cycles in which their signal is high.
- R5: Every counter saturates at 2^CNT_W-1 and does not wrap.
- R6: `strictErr` goes high in the cycle after the first mismatched sampled cycle and stays high until the next `winStart` or reset.
- R7: The index of each signal's first rising edge in the window is recorded (sampled cycles numbered from 0). A low level before the window counts as low, so a signal that is high in cycle 0 rises at 0. `tolErr` is set when both edges are seen and their indices differ by more than `tolDelay`. It is also set when only one edge has been seen and, at sampled cycle k (or at the close, taken as k = last index + 1), k minus its index exceeds `tolDelay`.
- R8: At the close, `tolErr` is set if `dutHighCount` and `refHighCount` differ by more than `tolWidth`. A pulse that is only delayed, or that drops out briefly, within both limits leaves `tolErr` low. `tolErr` is sticky until the next `winStart` or reset.
- R9: The `winEnd` cycle is the last sampled cycle. `windowOpen` falls after it. `done` is high for exactly one cycle, two cycles after the `winEnd` cycle. At that point the counts and both flags are final, and they then hold.
- R10: While the window is closed, input activity changes no count and no flag.
- R11: `tolDelay` and `tolWidth` are captured in the `winStart` cycle. Changing them later in the window has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| dutPulse | input | 1 | Pulse output under test |
| refPulse | input | 1 | Fault-free reference pulse |
| winStart | input | 1 | Opens (or restarts) the evaluation window |
| winEnd | input | 1 | Marks the last sampled cycle of the window |
| tolDelay | input | CNT_W | Allowed rising-edge offset in cycles |
| tolWidth | input | CNT_W | Allowed difference of high-cycle totals |
| mismatchCount | output | CNT_W | Cycles in which the two pulses differed |
| dutHighCount | output | CNT_W | Cycles with the pulse under test high |
| refHighCount | output | CNT_W | Cycles with the reference high |
| strictErr | output | 1 | Any-mismatch flag |
| tolErr | output | 1 | Out-of-tolerance flag |
| windowOpen | output | 1 | High while inputs are being sampled |
| done | output | 1 | One-cycle pulse when results are final |

## Verification
On every cycle, the properties check the following: counts are cleared by a start and frozen while the window is closed, saturated counts stay put, a mismatch always sets the strict flag and the flag is sticky, and the done pulse is one cycle long and only comes with a closed window. Several behaviours can only be shown by the directed scenarios with their hand-computed totals. These are the tolerant verdict for delayed, shifted-too-far, briefly glitched and never-rising pulses, the capture of tolerances at start only, the restart of an open window, and the exact cycle in which done appears.

// File: rtl/pem_pkg.sv
package pem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OPEN   = 2'd1,
    ST_SETTLE = 2'd2
  } pemState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;      // start of window: zero counters, load tolerances
    logic sample;     // this cycle's inputs belong to the window
    logic evalWidth;  // settle cycle: judge final high-time totals
  } pemCtl_t;
endpackage

// File: rtl/pem_sat_cnt.sv
module pem_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (inc && cnt != MAX)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pem_edge_stamp.sv
module pem_edge_stamp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         sample,
  input  logic         level,
  input  logic [W-1:0] now,
  output logic         seen,
  output logic [W-1:0] stamp
);
  logic prevLevel;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      prevLevel <= 1'b0;
      seen      <= 1'b0;
      stamp     <= '0;
    end else if (sample) begin
      prevLevel <= level;
      if (level && !prevLevel && !seen) begin
        seen  <= 1'b1;
        stamp <= now;
      end
    end
  end
endmodule

// File: rtl/pem_ctrl.sv
module pem_ctrl
  import pem_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    winStart,
  input  logic    winEnd,
  output pemCtl_t ctl,
  output logic    windowOpen,
  output logic    done
);
  pemState_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (winStart) begin
        state <= ST_OPEN;
      end else begin
        case (state)
          ST_OPEN:   if (winEnd) state <= ST_SETTLE;
          ST_SETTLE: begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
          default:   state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    windowOpen    = (state == ST_OPEN);
    ctl.clear     = winStart;
    ctl.sample    = (state == ST_OPEN) && !winStart;
    ctl.evalWidth = (state == ST_SETTLE) && !winStart;
  end
endmodule

// File: rtl/pem_datapath.sv
module pem_datapath
  import pem_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  pemCtl_t          ctl,
  input  logic             dutPulse,
  input  logic             refPulse,
  input  logic [CNT_W-1:0] tolDelay,
  input  logic [CNT_W-1:0] tolWidth,
  output logic [CNT_W-1:0] mismatchCount,
  output logic [CNT_W-1:0] dutHighCount,
  output logic [CNT_W-1:0] refHighCount,
  output logic             strictErr,
  output logic             tolErr
);
  localparam int NCH = 2;  // channel 0: under test, channel 1: reference

  logic [CNT_W-1:0] tolDelayQ, tolWidthQ;
  logic [CNT_W-1:0] timer;
  logic [NCH-1:0]   chLevel;
  logic [NCH-1:0]   chSeen;
  logic [CNT_W-1:0] chStamp [NCH];
  logic [CNT_W-1:0] chHigh  [NCH];

  assign chLevel = {refPulse, dutPulse};

  always_ff @(posedge clk) begin
    if (rst) begin
      tolDelayQ <= '0;
      tolWidthQ <= '0;
    end else if (ctl.clear) begin
      tolDelayQ <= tolDelay;
      tolWidthQ <= tolWidth;
    end
  end

  pem_sat_cnt #(.W(CNT_W)) uTimer (
    .clk(clk), .rst(rst), .clear(ctl.clear), .inc(ctl.sample), .cnt(timer)
  );

  pem_sat_cnt #(.W(CNT_W)) uMismatch (
    .clk(clk), .rst(rst), .clear(ctl.clear),
    .inc(ctl.sample && (dutPulse != refPulse)), .cnt(mismatchCount)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : gChan
    pem_sat_cnt #(.W(CNT_W)) uHigh (
      .clk(clk), .rst(rst), .clear(ctl.clear),
      .inc(ctl.sample && chLevel[ch]), .cnt(chHigh[ch])
    );
    pem_edge_stamp #(.W(CNT_W)) uEdge (
      .clk(clk), .rst(rst), .clear(ctl.clear), .sample(ctl.sample),
      .level(chLevel[ch]), .now(timer),
      .seen(chSeen[ch]), .stamp(chStamp[ch])
    );
  end

  assign dutHighCount = chHigh[0];
  assign refHighCount = chHigh[1];

  // tolerance evaluation
  logic [CNT_W-1:0] edgeGap, pendStamp, pendGap, widthGap;
  logic             delayViol, widthViol;

  always_comb begin
    edgeGap   = (chStamp[0] >= chStamp[1]) ? (chStamp[0] - chStamp[1])
                                           : (chStamp[1] - chStamp[0]);
    pendStamp = chSeen[0] ? chStamp[0] : chStamp[1];
    pendGap   = timer - pendStamp;
    widthGap  = (chHigh[0] >= chHigh[1]) ? (chHigh[0] - chHigh[1])
                                         : (chHigh[1] - chHigh[0]);
    delayViol = (chSeen[0] && chSeen[1] && (edgeGap > tolDelayQ)) ||
                ((chSeen[0] ^ chSeen[1]) && (pendGap > tolDelayQ));
    widthViol = widthGap > tolWidthQ;
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      strictErr <= 1'b0;
      tolErr    <= 1'b0;
    end else begin
      if (ctl.sample && (dutPulse != refPulse))
        strictErr <= 1'b1;
      if (((ctl.sample || ctl.evalWidth) && delayViol) ||
          (ctl.evalWidth && widthViol))
        tolErr <= 1'b1;
    end
  end
endmodule

// File: rtl/pulse_err_monitor.sv
module pulse_err_monitor
  import pem_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dutPulse,
  input  logic             refPulse,
  input  logic             winStart,
  input  logic             winEnd,
  input  logic [CNT_W-1:0] tolDelay,
  input  logic [CNT_W-1:0] tolWidth,
  output logic [CNT_W-1:0] mismatchCount,
  output logic [CNT_W-1:0] dutHighCount,
  output logic [CNT_W-1:0] refHighCount,
  output logic             strictErr,
  output logic             tolErr,
  output logic             windowOpen,
  output logic             done
);
  pemCtl_t ctl;

  pem_ctrl uCtrl (
    .clk(clk), .rst(rst), .winStart(winStart), .winEnd(winEnd),
    .ctl(ctl), .windowOpen(windowOpen), .done(done)
  );

  pem_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rst(rst), .ctl(ctl),
    .dutPulse(dutPulse), .refPulse(refPulse),
    .tolDelay(tolDelay), .tolWidth(tolWidth),
    .mismatchCount(mismatchCount), .dutHighCount(dutHighCount),
    .refHighCount(refHighCount), .strictErr(strictErr), .tolErr(tolErr)
  );
endmodule

// File: rtl/pem_checker.sv
module pem_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             winStart,
  input logic             dutPulse,
  input logic             refPulse,
  input logic [CNT_W-1:0] mismatchCount,
  input logic [CNT_W-1:0] dutHighCount,
  input logic [CNT_W-1:0] refHighCount,
  input logic             strictErr,
  input logic             tolErr,
  input logic             windowOpen,
  input logic             done
);
  localparam logic [CNT_W-1:0] MAX = '1;

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
    winStart |=> (mismatchCount == '0) && (dutHighCount == '0) &&
                 (refHighCount == '0) && !strictErr && !tolErr && windowOpen);

  assert_mismatch_counts_R3: assert property (@(posedge clk) disable iff (rst)
    windowOpen && !winStart && (dutPulse != refPulse) && (mismatchCount != MAX)
    |=> mismatchCount != $past(mismatchCount));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (mismatchCount == MAX) && !winStart |=> mismatchCount == MAX);

  assert_strict_sets_R6: assert property (@(posedge clk) disable iff (rst)
    windowOpen && !winStart && (dutPulse != refPulse) |=> strictErr);

  assert_strict_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    strictErr && !winStart |=> strictErr);

  assert_tol_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    tolErr && !winStart |=> tolErr);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_closed_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !windowOpen);

  assert_closed_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    !windowOpen && !winStart |=> $stable(mismatchCount) &&
      $stable(dutHighCount) && $stable(refHighCount) && $stable(strictErr));
endmodule

bind pulse_err_monitor pem_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rst(rst), .winStart(winStart),
  .dutPulse(dutPulse), .refPulse(refPulse),
  .mismatchCount(mismatchCount), .dutHighCount(dutHighCount),
  .refHighCount(refHighCount), .strictErr(strictErr), .tolErr(tolErr),
  .windowOpen(windowOpen), .done(done)
);

// File: tb/tb_pulse_err_monitor.sv
module tb_pulse_err_monitor;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dutPulse = 1'b0, refPulse = 1'b0;
  logic          winStart = 1'b0, winEnd = 1'b0;
  logic [CW-1:0] tolDelay = '0, tolWidth = '0;
  logic [CW-1:0] mismatchCount, dutHighCount, refHighCount;
  logic          strictErr, tolErr, windowOpen, done;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  pulse_err_monitor #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .dutPulse(dutPulse), .refPulse(refPulse),
    .winStart(winStart), .winEnd(winEnd), .tolDelay(tolDelay), .tolWidth(tolWidth),
    .mismatchCount(mismatchCount), .dutHighCount(dutHighCount),
    .refHighCount(refHighCount), .strictErr(strictErr), .tolErr(tolErr),
    .windowOpen(windowOpen), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // open window, run n sampled cycles (last is the winEnd cycle), stop at done cycle
  task automatic runWin(input int td, input int tw, input int tdLate, input int twLate,
                        input logic [31:0] dp, input logic [31:0] rp, input int n);
    @(negedge clk);
    winStart = 1'b1; tolDelay = CW'(td); tolWidth = CW'(tw);
    dutPulse = 1'b0; refPulse = 1'b0;
    @(negedge clk);
    winStart = 1'b0; tolDelay = CW'(tdLate); tolWidth = CW'(twLate);
    for (int i = 0; i < n; i++) begin
      dutPulse = dp[i]; refPulse = rp[i]; winEnd = (i == n - 1);
      @(negedge clk);
    end
    winEnd = 1'b0; dutPulse = 1'b0; refPulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkResult(input string tag, input int mm, input int dh, input int rh,
                             input int se, input int te);
    chk({tag, " R9 done"}, done, 1);
    chk({tag, " R9 window closed"}, windowOpen, 0);
    chk({tag, " R3 mismatchCount"}, mismatchCount, mm);
    chk({tag, " R4 dutHighCount"}, dutHighCount, dh);
    chk({tag, " R4 refHighCount"}, refHighCount, rh);
    chk({tag, " R6 strictErr"}, strictErr, se);
    chk({tag, " R7/R8 tolErr"}, tolErr, te);
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, done, 0);
    chk({tag, " R9 results hold"}, mismatchCount, mm);
  endtask

  task automatic testReset();
    chk("R1 mismatchCount", mismatchCount, 0);
    chk("R1 dutHighCount", dutHighCount, 0);
    chk("R1 refHighCount", refHighCount, 0);
    chk("R1 strictErr", strictErr, 0);
    chk("R1 tolErr", tolErr, 0);
    chk("R1 windowOpen", windowOpen, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic testMatch();
    runWin(2, 2, 2, 2, 32'h78, 32'h78, 10);
    checkResult("match", 0, 4, 4, 0, 0);
  endtask

  task automatic testOutside();  // R10: closed window ignores activity
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      dutPulse = i[0]; refPulse = ~i[0];
    end
    @(negedge clk);
    dutPulse = 1'b0; refPulse = 1'b0;
    @(negedge clk);
    chk("R10 mismatchCount frozen", mismatchCount, 0);
    chk("R10 dutHighCount frozen", dutHighCount, 4);
    chk("R10 strictErr untouched", strictErr, 0);
    chk("R10 done stays low", done, 0);
  endtask

  task automatic testDelayOk();  // R8 delayed pulse within limits
    runWin(2, 1, 2, 1, 32'h78, 32'h1E, 10);
    checkResult("delay-ok R8", 4, 4, 4, 1, 0);
  endtask

  task automatic testDelayBad();  // R7 edge offset 3 > 2
    runWin(2, 1, 2, 1, 32'hF0, 32'h1E, 10);
    checkResult("delay-bad R7", 6, 4, 4, 1, 1);
  endtask

  task automatic testGlitchOk();  // R8 brief dropout recovers
    runWin(2, 1, 2, 1, 32'h76, 32'h7E, 10);
    checkResult("glitch-ok R8", 1, 5, 6, 1, 0);
  endtask

  task automatic testGlitchBad();  // R8 width gap 3 > 1
    runWin(2, 1, 2, 1, 32'h46, 32'h7E, 10);
    checkResult("glitch-bad R8", 3, 3, 6, 1, 1);
  endtask

  task automatic testPending();  // R7 reference rose, test pulse never does
    runWin(2, 5, 2, 5, 32'h0, 32'h06, 10);
    checkResult("pending R7", 2, 0, 2, 1, 1);
  endtask

  task automatic testTolCapture();  // R11 late tolerance change ignored
    runWin(0, 0, 200, 200, 32'h0C, 32'h06, 8);
    checkResult("capture R11", 2, 2, 2, 1, 1);
  endtask

  task automatic testRestart();  // R2 restart of an open window
    @(negedge clk);
    winStart = 1'b1; tolDelay = 8'd1; tolWidth = 8'd1;
    @(negedge clk);
    winStart = 1'b0;
    dutPulse = 1'b1; refPulse = 1'b0;
    repeat (3) @(negedge clk);
    dutPulse = 1'b0;
    chk("R2 window open", windowOpen, 1);
    chk("R3 mismatchCount mid-window", mismatchCount, 3);
    chk("R6 strictErr mid-window", strictErr, 1);
    runWin(1, 1, 1, 1, 32'h0C, 32'h0C, 6);
    checkResult("restart R2", 0, 2, 2, 0, 0);
  endtask

  task automatic testSaturate();  // R5
    @(negedge clk);
    winStart = 1'b1; tolDelay = '0; tolWidth = '0;
    @(negedge clk);
    winStart = 1'b0;
    for (int i = 0; i < 300; i++) begin
      dutPulse = 1'b1; refPulse = 1'b0; winEnd = (i == 299);
      @(negedge clk);
    end
    winEnd = 1'b0; dutPulse = 1'b0;
    @(negedge clk);
    checkResult("saturate R5", 255, 255, 0, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    testMatch();
    testOutside();
    testDelayOk();
    testDelayBad();
    testGlitchOk();
    testGlitchBad();
    testPending();
    testTolCapture();
    testRestart();
    testSaturate();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule